// File: doc/BRIEF.md
# Modulo-N Synchronous Counter

This block is a counter that steps through the values 0 up to MODULUS-1 and then returns to 0, with every bit updated on the same clock edge. It recognises the final value MODULUS-1 and turns the next advance into a synchronous clear. Because of this the count never shows MODULUS or any larger value, not even for part of a cycle. A synchronous parallel load goes through the same next-state selection, so the count can be preset to any start value and carries on counting from there.

An advance happens only when the enable is high. The terminal flag is high while the count sits at its last value with the enable high. That flag can drive the enable of a higher-order stage that shares the same clock, which lets several counters be chained into one wider counter. The default build is modulo 6 on 3 bits.

Top module: `modn_counter`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the count to 0 on that edge.
- R2: With enable high and load low, a count v below MODULUS-1 becomes v+1 on the next edge.
- R3: With enable high and load low, a count equal to MODULUS-1 becomes 0 on the next edge. For the default MODULUS=6 the sequence is 0,1,2,3,4,5,0.
- R4: When enable is low and load is low, the count keeps its value, and this includes the value MODULUS-1.
- R5: When load is high at an edge, the count takes the value of loadValue on that edge. This holds whatever the enable and the current count are, and load takes priority over both the wrap and the increment.
- R6: termCount is high exactly when the count equals MODULUS-1 and enable is high. In all other cases it is low.
- R7: Starting from any reachable state (after reset, counting, or a load of a value below MODULUS), the count never equals or exceeds MODULUS.
- R8: The count changes only at rising clock edges. Between edges it stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Count enable |
| load | input | 1 | Synchronous load strobe |
| loadValue | input | WIDTH | Value to preset the count to |
| count | output | WIDTH | Current count |
| termCount | output | 1 | Count is at MODULUS-1 and enable is high |

## Verification
A bad next-state decode shows at the count on the very next edge. A missing wrap shows as the value MODULUS appearing one edge after MODULUS-1. A wrong priority shows as a loaded value being ignored when the load coincides with the terminal value. A bad terminal decode shows on termCount in the same cycle, because the flag is purely combinational from the count and the enable. The bench sweeps every count value against every combination of load, enable and preset value, and predicts each next count arithmetically. Every wrong transition therefore surfaces within one clock of the state that causes it.

// File: rtl/modn_pkg.sv
package modn_pkg;
  typedef struct packed {
    logic doLoad;
    logic doClear;
    logic doInc;
  } ctrlStrobes_t;
endpackage

// File: rtl/modn_ctrl.sv
module modn_ctrl
  import modn_pkg::*;
#(
  parameter int WIDTH   = 3,
  parameter int MODULUS = 6
) (
  input  logic             enable,
  input  logic             load,
  input  logic [WIDTH-1:0] count,
  output ctrlStrobes_t     strobes,
  output logic             termCount
);
  localparam logic [WIDTH-1:0] LastValue = WIDTH'(MODULUS - 1);

  logic atLast;

  // Full compare; for mod-6 this reduces to bit2 & bit0 over reachable states
  assign atLast    = (count == LastValue);
  assign termCount = enable & atLast;

  always_comb begin
    strobes = '0;
    if (load)            strobes.doLoad  = 1'b1;
    else if (termCount)  strobes.doClear = 1'b1;
    else if (enable)     strobes.doInc   = 1'b1;
  end
endmodule

// File: rtl/modn_datapath.sv
module modn_datapath
  import modn_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;
  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] toggleBits;

  // Serial enable chain: bit k toggles when all lower bits are one
  assign carryChain[0] = strobes.doInc;
  for (genvar k = 0; k < WIDTH; k++) begin : g_chain
    assign toggleBits[k]   = carryChain[k];
    assign carryChain[k+1] = carryChain[k] & countQ[k];
  end

  always_comb begin
    if (strobes.doLoad)       countNext = loadValue;
    else if (strobes.doClear) countNext = '0;
    else                      countNext = countQ ^ toggleBits;
  end

  always_ff @(posedge clk) begin
    if (rst) countQ <= '0;
    else     countQ <= countNext;
  end

  assign count = countQ;
endmodule

// File: rtl/modn_counter.sv
module modn_counter
  import modn_pkg::*;
#(
  parameter int WIDTH   = 3,
  parameter int MODULUS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             load,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] count,
  output logic             termCount
);
  ctrlStrobes_t strobes;

  modn_ctrl #(.WIDTH(WIDTH), .MODULUS(MODULUS)) i_ctrl (
    .enable    (enable),
    .load      (load),
    .count     (count),
    .strobes   (strobes),
    .termCount (termCount)
  );

  modn_datapath #(.WIDTH(WIDTH)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .loadValue (loadValue),
    .count     (count)
  );
endmodule

// File: rtl/modn_counter_checker.sv
module modn_counter_checker #(
  parameter int WIDTH   = 3,
  parameter int MODULUS = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             load,
  input logic [WIDTH-1:0] loadValue,
  input logic [WIDTH-1:0] count,
  input logic             termCount
);
  localparam logic [WIDTH-1:0] LastValue = WIDTH'(MODULUS - 1);

  logic seenReset = 1'b0;
  always_ff @(posedge clk) if (rst) seenReset <= 1'b1;

  assert_reset_zero_R1: assert property (@(posedge clk) rst |=> count == '0);

  assert_increment_R2: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (enable && !load && count != LastValue) |=> count == $past(count) + 1'b1);

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (enable && !load && count == LastValue) |=> count == '0);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!enable && !load) |=> $stable(count));

  assert_load_R5: assert property (@(posedge clk) disable iff (rst || !seenReset)
    load |=> count == $past(loadValue));

  assert_flag_R6: assert property (@(posedge clk) disable iff (rst || !seenReset)
    termCount == (enable && count == LastValue));

  assert_in_range_R7: assert property (@(posedge clk) disable iff (rst || !seenReset)
    (!load || loadValue < MODULUS) |=> count < MODULUS);
endmodule

bind modn_counter modn_counter_checker #(.WIDTH(WIDTH), .MODULUS(MODULUS)) i_checker (.*);

// File: tb/test_modn_counter.sv
`timescale 1ns/1ps
module test_modn_counter;
  localparam int WIDTH = 3;
  localparam int MODULUS = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic load = 1'b0;
  logic [WIDTH-1:0] loadValue = '0;
  logic [WIDTH-1:0] count;
  logic termCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  modn_counter #(.WIDTH(WIDTH), .MODULUS(MODULUS)) i_modn_counter (.*);

  task automatic check(input string req, input int actual, input int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic gotoValue(input int v);
    load = 1; loadValue = WIDTH'(v); enable = 0;
    stepEdge();
    load = 0;
  endtask

  initial begin
    rst = 1;
    stepEdge(); stepEdge();
    check("R1 reset", count, 0);
    rst = 0;

    // R3 R2 free-run sequence with R8 mid-cycle stability
    enable = 1;
    for (int i = 1; i <= 3 * MODULUS; i++) begin
      stepEdge();
      check("R2/R3 sequence", count, i % MODULUS);
      #1 check("R8 stable between edges", count, i % MODULUS);
      check("R7 range", int'(count < MODULUS), 1);
    end

    // exhaustive sweep: every start value, enable, load, loadValue
    for (int s = 0; s < MODULUS; s++)
      for (int e = 0; e < 2; e++)
        for (int l = 0; l < 2; l++)
          for (int d = 0; d < MODULUS; d++) begin
            int exp;
            if (l == 0 && d > 0) continue;
            gotoValue(s);
            enable = e[0]; load = l[0]; loadValue = WIDTH'(d);
            #0.5;
            check("R6 termCount", termCount, (e == 1 && s == MODULUS - 1) ? 1 : 0);
            if (l == 1) exp = d;
            else if (e == 0) exp = s;
            else exp = (s + 1) % MODULUS;
            stepEdge();
            if (l == 1) check("R5 load", count, exp);
            else if (e == 0) check("R4 hold", count, exp);
            else if (s == MODULUS - 1) check("R3 wrap", count, exp);
            else check("R2 increment", count, exp);
            load = 0;
          end

    // R4 hold at terminal over many edges
    gotoValue(MODULUS - 1);
    enable = 0;
    for (int i = 0; i < 5; i++) stepEdge();
    check("R4 hold at last", count, MODULUS - 1);
    check("R6 flag low when disabled", termCount, 0);

    // R1 reset overrides a pending load
    gotoValue(3);
    rst = 1; load = 1; loadValue = 4;
    stepEdge();
    check("R1 reset over load", count, 0);
    rst = 0; load = 0;

    // R5 preset then resume counting
    gotoValue(2); enable = 1;
    stepEdge(); check("R5 resume after preset", count, 3);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule